// File: doc/BRIEF.md
# Multi-Mode PWM Time Base

This block is the timing core of a pulse-width modulator. A programmable divider turns the system clock into a tick enable. A counter advances once per tick. It counts upward and wraps, counts downward and reloads, or counts up and down in a triangle. The compare and output stages downstream use the counter value, its direction, the tick, and two event strobes: one when the counter sits at zero, one when it sits at the period.

The period is written into a holding register. Depending on a control bit, it is either copied into the active period at the next zero event or applied at once. An external synchronisation pulse forces the counter to a programmed phase value and restarts the divider. A synchronisation output fires on every zero event, so several time bases can be chained: the synchronisation output of one module drives the synchronisation input of the next, and they run in lockstep with fixed phase offsets. A run bit in the control register starts and stops the module. Configuration is written through a simple write port with a 2-bit register address.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, no tick or strobe is asserted, the direction output is 1, the divider is 1, the phase is 0 and the active period is all ones.
- R2: Register address 1 holds the divider D in its low 8 bits. A tick is asserted in every D-th cycle while the module runs, a value of 0 acts as 1, and the first tick after start comes D-1 cycles after the run bit is set.
- R3: Bit 0 of the control register (address 0) is the run bit. While it is clear, no tick or strobe is produced and the counter holds its value; setting it again resumes from that value.
- R4: Control bits 2:1 select the mode. Codes 0 and 3 count up: on each tick the counter increments, and when it is at or above the active period it goes to 0. The direction output is 1.
- R5: Mode code 1 counts down: on each tick the counter decrements, and from 0 it loads the active period. The direction output is 0.
- R6: Mode code 2 counts up and down: the counter rises to the active period, then falls to 0, then rises again, so one full cycle lasts 2×period ticks. The direction output is 1 while rising (including at the peak) and 0 while falling (including at the bottom).
- R7: The zero strobe is high for exactly the tick cycle in which the counter is 0. The period strobe is high for exactly the tick cycle in which the counter equals the active period.
- R8: The synchronisation output equals the zero strobe.
- R9: With control bit 3 set, a write to address 2 changes only the holding period. The active period takes the holding value in the cycle after a zero strobe and at no other time.
- R10: With control bit 3 clear, a period written at address 2 is the active period from the next cycle on.
- R11: With the run bit and control bit 4 both set, a high synchronisation input loads the counter with the phase register (address 3) on the next edge, restarts the divider, sets the rising direction and suppresses the tick and both strobes in that cycle.
- R12: The synchronisation input has no effect when control bit 4 is clear or the run bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 divider, 2 period, 3 phase |
| wr_data_i | input | 16 | Register write data |
| sync_i | input | 1 | Synchronisation input, loads the phase |
| cnt_o | output | 16 | Counter value |
| cnt_up_o | output | 1 | Counting direction, 1 = rising |
| tick_o | output | 1 | Divided tick enable |
| zero_o | output | 1 | Zero event strobe |
| prd_o | output | 1 | Period event strobe |
| sync_o | output | 1 | Synchronisation output for the next module |

## Verification
The assertions assume that the write port and the synchronisation input are synchronous to the clock and free of unknown values, and that a pulse on the synchronisation input lasts a single cycle. The bench drives both only at the falling edge, and each synchronisation stimulus is a one-cycle pulse. The divider is written only while the run bit is clear, because a change mid-run may shorten one tick interval. Every sweep therefore programs the divider, the period and the phase before the run bit is set. Under these conditions the counter trajectory is a closed-form function of the cycle count.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDN   = 2'd2,
    CM_UP_ALT = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_DIV    = 2'd1,
    RA_PERIOD = 2'd2,
    RA_PHASE  = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_MODE_LO = 1;
  localparam int CTRL_SHADOW  = 3;
  localparam int CTRL_SYNC_EN = 4;
  localparam int CTRL_W       = 5;

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             zero_evt_i,
  output logic             run_o,
  output cnt_mode_e        mode_o,
  output logic             sync_en_o,
  output logic [DIV_W-1:0] div_o,
  output logic [CNT_W-1:0] prd_o,
  output logic [CNT_W-1:0] phase_o
);

  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  prd_sh_q, prd_sh_d;
  logic [CNT_W-1:0]  prd_act_q, prd_act_d;
  logic [CNT_W-1:0]  phase_q, phase_d;
  logic              wr_ctrl, wr_div, wr_prd, wr_phase;
  logic              shadow_on;

  // address decode
  always_comb begin
    wr_ctrl  = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_CTRL);
    wr_div   = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_DIV);
    wr_prd   = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_PERIOD);
    wr_phase = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_PHASE);
  end

  assign shadow_on = ctrl_q[CTRL_SHADOW];

  // next state
  always_comb begin
    ctrl_d   = ctrl_q;
    div_d    = div_q;
    prd_sh_d = prd_sh_q;
    phase_d  = phase_q;
    if (wr_ctrl)  ctrl_d   = wr_data_i[CTRL_W-1:0];
    if (wr_div)   div_d    = wr_data_i[DIV_W-1:0];
    if (wr_prd)   prd_sh_d = wr_data_i;
    if (wr_phase) phase_d  = wr_data_i;
    if (shadow_on) begin
      prd_act_d = zero_evt_i ? prd_sh_q : prd_act_q;
    end else begin
      prd_act_d = wr_prd ? wr_data_i : prd_sh_q;
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      div_q     <= DIV_RST;
      prd_sh_q  <= '1;
      prd_act_q <= '1;
      phase_q   <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      div_q     <= div_d;
      prd_sh_q  <= prd_sh_d;
      prd_act_q <= prd_act_d;
      phase_q   <= phase_d;
    end
  end

  assign run_o     = ctrl_q[CTRL_RUN];
  assign mode_o    = cnt_mode_e'(ctrl_q[CTRL_MODE_LO +: 2]);
  assign sync_en_o = ctrl_q[CTRL_SYNC_EN];
  assign div_o     = div_q;
  assign prd_o     = prd_act_q;
  assign phase_o   = phase_q;

  // R9: buffered period moves only on a zero event
  a_r9_shadow_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_on && !zero_evt_i) |=> $stable(prd_act_q));

  // R10: direct period write is visible next cycle
  a_r10_direct_prd : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shadow_on && wr_prd) |=> (prd_act_q == $past(wr_data_i)));

endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] eff_div;

  always_comb begin
    eff_div = (div_i == '0) ? ONE : div_i;
    tick_o  = run_i && !restart_i && (pre_q >= (eff_div - ONE));
    if (!run_i || restart_i || tick_o) pre_d = '0;
    else                               pre_d = pre_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  // R2: two ticks back to back only with a divider of one
  a_r2_tick_spacing : assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || eff_div == ONE));

  // R11: a restart yields a quiet cycle unless the divider is one
  a_r11_restart_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!tick_o || eff_div == ONE));

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] prd_i,
  input  cnt_mode_e        mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_up_o,
  output logic             zero_evt_o,
  output logic             prd_evt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             step;

  assign step = tick_i && !load_i;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (load_i) begin
      cnt_d = phase_i;
      up_d  = 1'b1;
    end else if (tick_i) begin
      unique case (mode_i)
        CM_DOWN: begin
          cnt_d = (cnt_q == '0) ? prd_i : cnt_q - ONE;
        end
        CM_UPDN: begin
          if (up_q) begin
            if (cnt_q >= prd_i) begin
              up_d  = 1'b0;
              cnt_d = (prd_i == '0) ? '0 : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              up_d  = 1'b1;
              cnt_d = (prd_i == '0) ? '0 : cnt_q + ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: begin
          cnt_d = (cnt_q >= prd_i) ? '0 : cnt_q + ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  always_comb begin
    unique case (mode_i)
      CM_DOWN: cnt_up_o = 1'b0;
      CM_UPDN: cnt_up_o = up_q;
      default: cnt_up_o = 1'b1;
    endcase
    zero_evt_o = step && (cnt_q == '0);
    prd_evt_o  = step && (cnt_q == prd_i);
  end

  assign cnt_o = cnt_q;

  // R3: no tick and no load keeps the count
  a_r3_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  // R4: up count wraps to zero at the period
  a_r4_up_wrap : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (mode_i == CM_UP || mode_i == CM_UP_ALT) && cnt_q >= prd_i) |=> (cnt_q == '0));

  // R5: down count reloads the period from zero
  a_r5_down_reload : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_i == CM_DOWN && cnt_q == '0) |=> (cnt_q == $past(prd_i)));

  // R6: triangle turns downward at the peak
  a_r6_peak_turn : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_i == CM_UPDN && up_q && cnt_q >= prd_i && prd_i != '0) |=> !up_q);

  // R11: phase load
  a_r11_phase_load : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(phase_i) && up_q));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             sync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_up_o,
  output logic             tick_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             sync_o
);

  logic             run, sync_en, load;
  cnt_mode_e        mode;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] prd_act, phase;
  logic             zero_evt, prd_evt;

  ptb_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .zero_evt_i (zero_evt),
    .run_o      (run),
    .mode_o     (mode),
    .sync_en_o  (sync_en),
    .div_o      (div),
    .prd_o      (prd_act),
    .phase_o    (phase)
  );

  assign load = run && sync_en && sync_i;

  ptb_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (load),
    .div_i     (div),
    .tick_o    (tick_o)
  );

  ptb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_o),
    .load_i     (load),
    .phase_i    (phase),
    .prd_i      (prd_act),
    .mode_i     (mode),
    .cnt_o      (cnt_o),
    .cnt_up_o   (cnt_up_o),
    .zero_evt_o (zero_evt),
    .prd_evt_o  (prd_evt)
  );

  assign zero_o = zero_evt;
  assign prd_o  = prd_evt;
  assign sync_o = zero_evt;

  // R7: strobes only in tick cycles
  a_r7_strobe_on_tick : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o || prd_o) |-> tick_o);

  // R12: a blocked sync input without a tick leaves the count alone
  a_r12_sync_blocked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !(run && sync_en) && !tick_o) |=> $stable(cnt_o));

  // R3: stopped module produces no tick
  a_r3_no_tick_stopped : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> !tick_o);

endmodule

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        sync_i = 1'b0;
  logic [15:0] cnt_o;
  logic        cnt_up_o, tick_o, zero_o, prd_o, sync_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwm_timebase u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .sync_i(sync_i), .cnt_o(cnt_o), .cnt_up_o(cnt_up_o),
    .tick_o(tick_o), .zero_o(zero_o), .prd_o(prd_o), .sync_o(sync_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // called at a falling edge, returns at the next one
  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1;
    wr_addr_i = 2'(a);
    wr_data_i = 16'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int model_val(input int md, input int p, input int t);
    int s;
    if (md == 1) return (p + 1 - (t % (p + 1))) % (p + 1);
    if (md == 2) begin
      if (p == 0) return 0;
      s = t % (2 * p);
      return (s <= p) ? s : 2 * p - s;
    end
    return t % (p + 1);
  endfunction

  function automatic logic model_dir(input int md, input int p, input int t);
    int s;
    if (md == 1) return 1'b0;
    if (md != 2) return 1'b1;
    s = t % (2 * p);
    if (s == 0) return (t == 0);
    return (s <= p);
  endfunction

  // R2, R4, R5, R6, R7, R8 sweep
  task automatic sweep(input int md, input int p, input int d);
    int deff, n, t, v;
    logic tk, zr, pr;
    logic [20:0] act, exp;
    string req;
    req = (md == 1) ? "R5/R2/R7/R8" : (md == 2) ? "R6/R2/R7/R8" : "R4/R2/R7/R8";
    do_reset();
    wr(2, p);
    wr(1, d);
    wr(0, 1 | (md << 1));
    deff = (d == 0) ? 1 : d;
    n = 2 * (2 * p + 2) * deff + 2;
    for (int m = 0; m < n; m++) begin
      tk = ((m % deff) == deff - 1);
      t = m / deff;
      v = model_val(md, p, t);
      zr = tk && (v == 0);
      pr = tk && (v == p);
      exp = {16'(v), tk, zr, pr, zr, model_dir(md, p, t)};
      act = {cnt_o, tick_o, zero_o, prd_o, sync_o, cnt_up_o};
      chk(req, 32'(act), 32'(exp));
      @(negedge clk);
    end
  endtask

  initial begin
    #750us;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seq_sh[10];
    int prd_sh[10];
    int held;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 cnt", 32'(cnt_o), 0);
    chk("R1 strobes", {tick_o, zero_o, prd_o, sync_o}, 0);
    chk("R1 dir", 32'(cnt_up_o), 1);

    for (int md = 0; md < 4; md++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int di = 0; di < 3; di++) begin
          int pv[4] = '{0, 1, 2, 5};
          int dv[3] = '{0, 1, 3};
          if (!(md == 2 && pv[pi] == 0)) sweep(md, pv[pi], dv[di]);
        end
      end
    end

    // R3 stop and resume
    do_reset();
    wr(2, 9);
    wr(0, 1);
    step(3);
    chk("R3 running", 32'(cnt_o), 3);
    wr(0, 0);
    chk("R3 last tick", 32'(cnt_o), 4);
    for (int i = 0; i < 5; i++) begin
      chk("R3 held", {cnt_o, tick_o, zero_o, prd_o}, {16'd4, 3'b000});
      @(negedge clk);
    end
    wr(0, 1);
    chk("R3 resume", 32'(cnt_o), 4);
    step(1);
    chk("R3 resume step", 32'(cnt_o), 5);

    // R9 buffered period
    seq_sh = '{2, 3, 0, 1, 2, 3, 4, 5, 6, 0};
    prd_sh = '{0, 1, 0, 0, 0, 0, 0, 0, 1, 0};
    do_reset();
    wr(2, 3);
    wr(0, 1 | 8);
    step(1);
    chk("R9 pre", 32'(cnt_o), 1);
    wr(2, 6);
    for (int i = 0; i < 10; i++) begin
      chk("R9 seq", {cnt_o, prd_o}, {16'(seq_sh[i]), 1'(prd_sh[i])});
      @(negedge clk);
    end

    // R10 direct period
    do_reset();
    wr(2, 3);
    wr(0, 1);
    step(1);
    chk("R10 pre", 32'(cnt_o), 1);
    wr(2, 2);
    chk("R10 new peak", {cnt_o, prd_o}, {16'd2, 1'b1});
    step(1);
    chk("R10 wrap", 32'(cnt_o), 0);
    step(2);
    chk("R10 again", {cnt_o, prd_o}, {16'd2, 1'b1});

    // R11 phase load with divider restart
    do_reset();
    wr(3, 6);
    wr(2, 9);
    wr(1, 3);
    wr(0, 1 | 16);
    step(1);
    chk("R11 before", 32'(cnt_o), 0);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R11 loaded", {cnt_o, tick_o}, {16'd6, 1'(i == 2)});
      @(negedge clk);
    end
    chk("R11 next", 32'(cnt_o), 7);

    // R11 strobe suppression
    do_reset();
    wr(3, 4);
    wr(2, 9);
    wr(0, 1 | 16);
    chk("R11 zero pending", {tick_o, zero_o}, 2'b11);
    sync_i = 1'b1;
    #1;
    chk("R11 suppressed", {tick_o, zero_o, prd_o, sync_o}, 0);
    @(negedge clk);
    sync_i = 1'b0;
    chk("R11 phase", 32'(cnt_o), 4);
    step(1);
    chk("R11 continue", 32'(cnt_o), 5);

    // R12 sync disabled by control bit
    do_reset();
    wr(3, 6);
    wr(2, 9);
    wr(0, 1);
    step(2);
    chk("R12 pre", 32'(cnt_o), 2);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    chk("R12 ignored", 32'(cnt_o), 3);
    // R12 sync while stopped
    wr(0, 16);
    held = int'(cnt_o);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    step(1);
    chk("R12 stopped", 32'(cnt_o), 32'(held));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule